// File: doc/BRIEF.md
# Synchronous Rectifier Zero-Current Gate Control

This block decides, cycle by cycle, whether the low-side (synchronous rectifier) switch of a buck converter may stay on. The PWM core requests the low-side drive. This block passes the request through unless a digital zero-current indication shows that the inductor current is about to reverse. When that indication is accepted, the rectifier is latched off for the rest of the switching period. The latch is released by the strobe that starts the next PWM period.

The comparator behind the zero-current flag is noisy right after the rectifier turns on, so the flag is ignored for a blanking window. The window is measured in clock cycles and is derived from the clock period and the required blanking time (75 ns at the default 125 MHz clock, which gives 10 cycles). A 2-bit mode sets when the cutoff may act:
- In source-only mode the cutoff is always armed. This suits converters that run in parallel.
- In pre-bias mode the cutoff is armed only while soft-start runs, so startup into a charged output never pulls current from it.
- In source/sink mode the cutoff is never armed.

Two overrides sit above the cutoff. Shutdown forces the drive low. A fault forces it high.

Top module: `srz_gate`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `lo_gate` is 0.
- R2: If `shdn` is 1 at a clock edge, `lo_gate` is 0 after that edge, whatever the other inputs are (fault included).
- R3: If `fault` is 1 and `shdn` is 0 at a clock edge, `lo_gate` is 1 after that edge, even if the request is low or the cutoff latch is set.
- R4: With `mode` = 2'b10 (source/sink) and no override, `lo_gate` equals the `lo_req` sampled at the previous edge, and `zc_flag` has no effect.
- R5: `zc_flag` is ignored at the edge where `lo_req` is first seen high (the rising edge of the request) and at the following BLANK_CYCLES-1 edges. BLANK_CYCLES is 10 by default.
- R6: With `mode` = 2'b00 (source-only), `lo_req` high, blanking over and `zc_flag` high at an edge without `cyc_start`, the cutoff latch sets and `lo_gate` is 0 after that edge.
- R7: Once set, the cutoff latch keeps `lo_gate` at 0 after `zc_flag` falls. It clears at the next edge with `cyc_start` high, and `lo_gate` then follows `lo_req` again.
- R8: With `mode` = 2'b01 (pre-bias), the cutoff acts only at edges where `ss_active` is 1. When `ss_active` is 0, `zc_flag` has no effect.
- R9: `mode` = 2'b11 behaves exactly as 2'b10.
- R10: When `cyc_start` and an acceptable `zc_flag` occur at the same edge, the clear wins and `lo_gate` follows `lo_req`.
- R11: A latch set earlier in a period holds `lo_gate` at 0 even if `mode` changes to source/sink. It holds until the next `cyc_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lo_req | input | 1 | Low-side enable requested by the PWM core |
| cyc_start | input | 1 | One-cycle strobe at the start of each PWM period |
| zc_flag | input | 1 | Switch node above the small negative zero-current threshold |
| ss_active | input | 1 | Soft-start in progress |
| mode | input | 2 | 00 source-only, 01 pre-bias, 10/11 source/sink |
| shdn | input | 1 | Shutdown: force the low-side drive off |
| fault | input | 1 | Fault: force the low-side drive on |
| lo_gate | output | 1 | Gated low-side enable, registered |

## Verification
The bench targets the edge of the blanking window: a `zc_flag` held high from the rising edge of the request must survive exactly BLANK_CYCLES edges. A counter that is off by one would cut the rectifier one edge early or one edge late.

It also covers the following cases:
- It collides the period-start clear with an accepted zero-current flag. A design with the wrong priority would leave the rectifier off for a whole period.
- It changes the mode while the latch is set. A design that gated the latch with the current mode would turn the rectifier back on mid-period.
- It drives pre-bias mode with soft-start both on and off, to catch a decoder that ignores `ss_active`.
- It layers fault over shutdown, to prove the order of the overrides.

// File: rtl/srz_pkg.sv
package srz_pkg;

    typedef enum logic [1:0] {
        SRZ_SRC_ONLY = 2'b00,
        SRZ_PREBIAS  = 2'b01,
        SRZ_BIDIR    = 2'b10,
        SRZ_BIDIR_X  = 2'b11
    } srz_mode_e;

    // Whether an accepted zero-current event may cut the rectifier.
    function automatic logic srz_cut_allowed(input logic [1:0] mode, input logic ss_on);
        logic allowed;
        case (srz_mode_e'(mode))
            SRZ_SRC_ONLY: allowed = 1'b1;
            SRZ_PREBIAS:  allowed = ss_on;
            default:      allowed = 1'b0;
        endcase
        return allowed;
    endfunction

endpackage

// File: rtl/srz_blank_timer.sv
module srz_blank_timer #(
    parameter int unsigned BLANK_CYCLES = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lo_req,
    output logic req_rise,
    output logic blank_win
);
    localparam int unsigned CW = (BLANK_CYCLES > 1) ? $clog2(BLANK_CYCLES) : 1;
    localparam logic [CW-1:0] LOAD = CW'(BLANK_CYCLES - 1);

    typedef struct packed {
        logic          req;
        logic [CW-1:0] left;
    } tmr_t;

    tmr_t s_d, s_q;

    assign req_rise  = lo_req & ~s_q.req;
    assign blank_win = req_rise | (s_q.left != '0);

    always_comb begin
        s_d     = s_q;
        s_d.req = lo_req;
        if (req_rise) begin
            s_d.left = LOAD;
        end else if (s_q.left != '0) begin
            s_d.left = s_q.left - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/srz_mode_decode.sv
module srz_mode_decode
    import srz_pkg::*;
(
    input  logic [1:0] mode,
    input  logic       ss_active,
    output logic       cut_en
);
    always_comb begin
        cut_en = srz_cut_allowed(mode, ss_active);
    end
endmodule

// File: rtl/srz_cut_latch.sv
module srz_cut_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_start,
    input  logic set_req,
    output logic cut_next,
    output logic cut_hold
);
    typedef struct packed {
        logic cut;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (cyc_start) begin
            s_d.cut = 1'b0;
        end else if (set_req) begin
            s_d.cut = 1'b1;
        end
    end

    assign cut_next = s_d.cut;
    assign cut_hold = s_q.cut;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/srz_gate.sv
module srz_gate #(
    parameter int unsigned CLK_PERIOD_PS = 8000,
    parameter int unsigned BLANK_PS      = 75000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       lo_req,
    input  logic       cyc_start,
    input  logic       zc_flag,
    input  logic       ss_active,
    input  logic [1:0] mode,
    input  logic       shdn,
    input  logic       fault,
    output logic       lo_gate
);
    localparam int unsigned BLANK_RAW    = (BLANK_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int unsigned BLANK_CYCLES = (BLANK_RAW < 1) ? 1 : BLANK_RAW;

    typedef struct packed {
        logic gate;
    } out_t;

    out_t s_d, s_q;

    logic req_rise;
    logic blank_win;
    logic cut_en;
    logic zc_take;
    logic cut_next;
    logic cut_hold;

    srz_blank_timer #(
        .BLANK_CYCLES(BLANK_CYCLES)
    ) u_blank (
        .clk      (clk),
        .rst_n    (rst_n),
        .lo_req   (lo_req),
        .req_rise (req_rise),
        .blank_win(blank_win)
    );

    srz_mode_decode u_mode (
        .mode     (mode),
        .ss_active(ss_active),
        .cut_en   (cut_en)
    );

    assign zc_take = lo_req & ~blank_win & zc_flag & cut_en;

    srz_cut_latch u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_start(cyc_start),
        .set_req  (zc_take),
        .cut_next (cut_next),
        .cut_hold (cut_hold)
    );

    always_comb begin
        s_d = s_q;
        if (shdn) begin
            s_d.gate = 1'b0;
        end else if (fault) begin
            s_d.gate = 1'b1;
        end else begin
            s_d.gate = lo_req & ~cut_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign lo_gate = s_q.gate;
endmodule

// File: rtl/srz_gate_chk.sv
module srz_gate_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lo_req,
    input logic       cyc_start,
    input logic       zc_flag,
    input logic       ss_active,
    input logic [1:0] mode,
    input logic       shdn,
    input logic       fault,
    input logic       lo_gate,
    input logic       blank_win,
    input logic       cut_hold
);
    a_r2_shutdown_low: assert property (@(posedge clk) disable iff (!rst_n)
        shdn |=> !lo_gate);

    a_r3_fault_high: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !shdn) |=> lo_gate);

    a_r4_bidir_follow: assert property (@(posedge clk) disable iff (!rst_n)
        (mode[1] && cyc_start && !shdn && !fault) |=> (lo_gate == $past(lo_req)));

    a_r5_blank_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_req && blank_win && !cut_hold && !shdn && !fault) |=> lo_gate);

    a_r6_src_cut: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && lo_req && !blank_win && zc_flag && !cyc_start && !shdn && !fault)
        |=> !lo_gate);

    a_r7_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cut_hold && !cyc_start && !shdn && !fault) |=> !lo_gate);

    a_r8_prebias_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && !ss_active && lo_req && !cut_hold && !cyc_start && !shdn && !fault)
        |=> lo_gate);
endmodule

bind srz_gate srz_gate_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lo_req   (lo_req),
    .cyc_start(cyc_start),
    .zc_flag  (zc_flag),
    .ss_active(ss_active),
    .mode     (mode),
    .shdn     (shdn),
    .fault    (fault),
    .lo_gate  (lo_gate),
    .blank_win(blank_win),
    .cut_hold (cut_hold)
);

// File: tb/srz_gate_bench.sv
`timescale 1ns/1ps
module srz_gate_bench;
    localparam int BLANK = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lo_req = 1'b0;
    logic       cyc_start = 1'b0;
    logic       zc_flag = 1'b0;
    logic       ss_active = 1'b0;
    logic [1:0] mode = 2'b10;
    logic       shdn = 1'b0;
    logic       fault = 1'b0;
    logic       lo_gate;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;
    bit    running = 1'b0;
    string cur_tag = "R1";

    bit m_prev, m_cut, m_gate;
    int m_left;

    always #4 clk = ~clk;

    srz_gate u_srz_gate (
        .clk(clk), .rst_n(rst_n), .lo_req(lo_req), .cyc_start(cyc_start),
        .zc_flag(zc_flag), .ss_active(ss_active), .mode(mode),
        .shdn(shdn), .fault(fault), .lo_gate(lo_gate)
    );

    // Behavioural reference model, written from the requirements.
    always @(posedge clk) begin
        bit ign, armed;
        if (!rst_n) begin
            m_prev = 0; m_left = 0; m_cut = 0; m_gate = 0;
        end else begin
            ign = 0;
            if (lo_req && !m_prev) begin
                ign = 1;
                m_left = BLANK - 1;
            end else if (m_left > 0) begin
                ign = 1;
                m_left = m_left - 1;
            end
            armed = (mode == 2'b00) || (mode == 2'b01 && ss_active);
            if (cyc_start) m_cut = 0;
            else if (lo_req && !ign && zc_flag && armed) m_cut = 1;
            if (shdn) m_gate = 0;
            else if (fault) m_gate = 1;
            else m_gate = lo_req && !m_cut;
            m_prev = lo_req;
        end
    end

    task automatic chk(input string tag, input logic exp_v);
        n_checks++;
        if (lo_gate !== exp_v) begin
            n_fail++;
            $display("FAIL %s: lo_gate=%0b expected %0b at %0t", tag, lo_gate, exp_v, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && running) chk(cur_tag, m_gate);
    end

    task automatic tick();
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) tick();
        chk("R1", 1'b0);
        rst_n = 1'b1;
        tick();
        chk("R1", 1'b0);
        running = 1'b1;

        // R4: source/sink passes the request, zc ignored
        cur_tag = "R4";
        mode = 2'b10; zc_flag = 1'b1;
        for (int i = 0; i < 20; i++) begin
            lo_req = (i % 3) != 0;
            cyc_start = (i % 5) == 0;
            tick();
            chk("R4", lo_req);
        end

        // R9: code 11 same as 10
        cur_tag = "R9";
        mode = 2'b11;
        for (int i = 0; i < 20; i++) begin
            lo_req = (i % 4) != 1;
            cyc_start = (i % 7) == 0;
            tick();
            chk("R9", lo_req);
        end

        // R5/R6/R7: source-only blanking, cut, hold, release
        cur_tag = "R5";
        mode = 2'b00; lo_req = 1'b0; cyc_start = 1'b1; zc_flag = 1'b0;
        tick();
        cyc_start = 1'b0; lo_req = 1'b1; zc_flag = 1'b1;
        for (int i = 0; i < BLANK; i++) begin
            tick();
            chk("R5", 1'b1);
        end
        cur_tag = "R6";
        tick();
        chk("R6", 1'b0);
        cur_tag = "R7";
        zc_flag = 1'b0;
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R7", 1'b0);
        end
        cyc_start = 1'b1;
        tick();
        chk("R7", 1'b1);
        cyc_start = 1'b0;
        tick();
        chk("R7", 1'b1);

        // R10: clear beats an accepted zc at the same edge
        cur_tag = "R10";
        zc_flag = 1'b1; cyc_start = 1'b1;
        tick();
        chk("R10", 1'b1);
        cyc_start = 1'b0;
        tick();
        chk("R6", 1'b0);

        // R11: latched cut survives a mode change to source/sink
        cur_tag = "R11";
        mode = 2'b10; zc_flag = 1'b0;
        tick();
        chk("R11", 1'b0);
        cyc_start = 1'b1;
        tick();
        chk("R11", 1'b1);
        cyc_start = 1'b0;

        // R8: pre-bias cuts only during soft-start
        cur_tag = "R8";
        mode = 2'b01; ss_active = 1'b1; lo_req = 1'b0;
        tick();
        lo_req = 1'b1; zc_flag = 1'b1;
        repeat (BLANK) tick();
        tick();
        chk("R8", 1'b0);
        cyc_start = 1'b1; lo_req = 1'b0;
        tick();
        cyc_start = 1'b0; ss_active = 1'b0; lo_req = 1'b1;
        for (int i = 0; i < BLANK + 3; i++) begin
            tick();
            chk("R8", 1'b1);
        end

        // R3/R2: fault forces on, shutdown beats fault
        cur_tag = "R3";
        mode = 2'b00;
        tick();
        chk("R6", 1'b0);
        fault = 1'b1;
        tick();
        chk("R3", 1'b1);
        lo_req = 1'b0;
        tick();
        chk("R3", 1'b1);
        cur_tag = "R2";
        shdn = 1'b1;
        tick();
        chk("R2", 1'b0);
        fault = 1'b0; lo_req = 1'b1;
        tick();
        chk("R2", 1'b0);
        shdn = 1'b0; cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;

        // Mixed stimulus, compared against the model every cycle
        cur_tag = "RND";
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            if (i % 250 == 0) mode = r[23:22];
            lo_req    = r[0] | r[1];
            cyc_start = (r[6:3] == 4'd0);
            zc_flag   = r[8] & r[9];
            ss_active = r[10] | r[11];
            shdn      = (r[16:12] == 5'd0);
            fault     = (r[21:17] == 5'd0);
            tick();
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule